// File: doc/BRIEF.md
# AXI burst address generator

This block turns one AXI burst command into the sequence of per-beat addresses that an AXI master or slave walks through. A command carries a start address, an 8-bit length field, a 3-bit size field and a 2-bit burst type. It is taken on a valid/ready handshake. The block then presents one address per beat on a second valid/ready interface and flags the final beat.

Three burst types are handled. A FIXED burst keeps one address. An INCR burst steps through memory. A WRAP burst steps inside a window and folds back to the bottom of that window once it reaches the top. Commands that break the burst rules are still accepted, but they produce no beats. Instead they raise a one-cycle error pulse, so that the surrounding logic can report a parameter error.

Top module: `burst_addr_seq`

## Requirements
- R1: A legal burst produces exactly length field + 1 beats. `beat_last` is high on the final beat and on no other beat.
- R2: The bytes per beat equal 2 to the power of the size field (0 gives 1 byte, 7 gives 128 bytes). Each address step moves by that amount.
- R3: A FIXED burst (type code 0) repeats the start address on every beat.
- R4: An INCR burst (type code 1) emits the start address first. Each later beat is the previous address rounded down to the beat size, plus the bytes per beat, so only the first beat may be unaligned.
- R5: A WRAP burst (type code 2) uses a boundary: the start address rounded down to a multiple of bytes per beat × beat count. Its address advances like INCR, except that a next address equal to boundary + bytes per beat × beat count is replaced by the boundary. For example, size 1, length field 3 and start 0x24 give 0x24, 0x26, 0x20, 0x22.
- R6: A WRAP command whose beat count is not 2, 4, 8 or 16, or whose start address is not a multiple of the bytes per beat, is accepted but emits no beats and raises `cmd_err`.
- R7: A FIXED command with more than 16 beats, and any command with type code 3, is accepted but emits no beats and raises `cmd_err`.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_addr` and `beat_last` hold their values. `cmd_ready` stays low from the accepting edge of a legal command until its final beat has been taken.
- R9: After reset, `cmd_ready` is high and both `beat_valid` and `cmd_err` are low.
- R10: `cmd_err` is high for exactly the one cycle after the edge that accepts an illegal command, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command |
| cmd_addr | input | ADDR_W | Start address |
| cmd_len | input | 8 | Length field (beats − 1) |
| cmd_size | input | 3 | Size field (log2 of bytes per beat) |
| cmd_kind | input | 2 | Burst type: 0 FIXED, 1 INCR, 2 WRAP, 3 reserved |
| cmd_err | output | 1 | One-cycle pulse after an illegal command is taken |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | The consumer takes the presented beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_last | output | 1 | The current beat is the final one |

## Verification
The assertions check on every cycle that a stalled beat holds still and that no command is taken while a burst is running. They also check that FIXED beats repeat, that each INCR step moves by exactly one aligned beat, and that every WRAP address stays inside its window. Finally they check that a final beat is never followed at once by another beat, and that an error pulse always follows an accepted command. The full expected address sequences cannot be shown by the assertions, and neither can the exact beat counts, where the fold happens, or which commands count as illegal. Those come only from the bench's sweep over burst types, sizes, lengths and start addresses under a stalling consumer, compared with arithmetic done in the bench.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int LEN_W        = 8;
    localparam int SIZE_W       = 3;
    localparam int KIND_W       = 2;
    localparam int BYTES_W      = (1 << SIZE_W);   // wide enough for 2**7
    localparam int SHORT_BEATS  = 16;              // cap for FIXED and WRAP

    typedef enum logic [KIND_W-1:0] {
        KIND_FIXED = 2'd0,
        KIND_INCR  = 2'd1,
        KIND_WRAP  = 2'd2,
        KIND_RSVD  = 2'd3
    } burst_kind_e;

    // bytes carried by one beat for a given size code
    function automatic logic [BYTES_W-1:0] beat_bytes(input logic [SIZE_W-1:0] sz);
        return BYTES_W'(1) << sz;
    endfunction

    // wrap bursts need a power-of-two beat count between 2 and 16
    function automatic logic wrap_len_ok(input logic [LEN_W-1:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

    // log2 of the beat count for the legal wrap lengths
    function automatic logic [2:0] wrap_beats_log2(input logic [LEN_W-1:0] len);
        case (len)
            8'd1:    return 3'd1;
            8'd3:    return 3'd2;
            8'd7:    return 3'd3;
            8'd15:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/burst_cmd_check.sv
module burst_cmd_check
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  burst_kind_e       kind,
    output logic              legal,
    output logic [ADDR_W-1:0] bound,
    output logic [ADDR_W-1:0] span
);

    logic [ADDR_W-1:0] unit;
    logic              aligned;

    always_comb begin
        unit    = ADDR_W'(beat_bytes(size));
        aligned = ((addr & (unit - 1'b1)) == '0);
        span    = unit << wrap_beats_log2(len);
        bound   = addr & ~(span - 1'b1);
        case (kind)
            KIND_FIXED: legal = (int'(len) < SHORT_BEATS);
            KIND_INCR:  legal = 1'b1;
            KIND_WRAP:  legal = wrap_len_ok(len) && aligned;
            default:    legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  burst_kind_e       kind,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] bound,
    input  logic [ADDR_W-1:0] span,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] unit;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        unit    = ADDR_W'(beat_bytes(size));
        stepped = (cur & ~(unit - 1'b1)) + unit;
        case (kind)
            KIND_INCR: nxt = stepped;
            KIND_WRAP: nxt = (stepped == bound + span) ? bound : stepped;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic [KIND_W-1:0] cmd_kind,
    output logic              cmd_err,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last
);

    typedef struct packed {
        logic              busy;
        burst_kind_e       kind;
        logic [SIZE_W-1:0] size;
        logic [LEN_W-1:0]  remain;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] bound;
        logic [ADDR_W-1:0] span;
    } walk_t;

    walk_t             st;
    logic              err_q;
    logic              cmd_legal;
    logic [ADDR_W-1:0] cmd_bound;
    logic [ADDR_W-1:0] cmd_span;
    logic [ADDR_W-1:0] next_addr;
    logic              accept;
    logic              take;
    burst_kind_e       kind_in;

    assign kind_in = burst_kind_e'(cmd_kind);

    burst_cmd_check #(.ADDR_W(ADDR_W)) u_check (
        .addr  (cmd_addr),
        .len   (cmd_len),
        .size  (cmd_size),
        .kind  (kind_in),
        .legal (cmd_legal),
        .bound (cmd_bound),
        .span  (cmd_span)
    );

    burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur   (st.addr),
        .kind  (st.kind),
        .size  (st.size),
        .bound (st.bound),
        .span  (st.span),
        .nxt   (next_addr)
    );

    assign cmd_ready = !st.busy;
    assign accept    = cmd_valid && cmd_ready;
    assign take      = st.busy && beat_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !cmd_legal;
            if (accept && cmd_legal) begin
                st.busy   <= 1'b1;
                st.kind   <= kind_in;
                st.size   <= cmd_size;
                st.remain <= cmd_len;
                st.addr   <= cmd_addr;
                st.bound  <= cmd_bound;
                st.span   <= cmd_span;
            end else if (take) begin
                if (st.remain == '0) begin
                    st.busy <= 1'b0;
                end else begin
                    st.addr   <= next_addr;
                    st.remain <= st.remain - 1'b1;
                end
            end
        end
    end

    assign beat_valid = st.busy;
    assign beat_addr  = st.addr;
    assign beat_last  = st.busy && (st.remain == '0);
    assign cmd_err    = err_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [SIZE_W-1:0] cmd_size,
    input logic [KIND_W-1:0] cmd_kind,
    input logic              cmd_err,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              beat_last
);

    logic [KIND_W-1:0] k_kind;
    logic [SIZE_W-1:0] k_size;
    logic [LEN_W-1:0]  k_len;
    logic [ADDR_W-1:0] k_addr;
    logic [ADDR_W-1:0] k_bytes;
    logic [ADDR_W-1:0] k_span;
    logic [ADDR_W-1:0] k_bound;

    always_ff @(posedge clk) begin
        if (rst) begin
            k_kind <= '0;
            k_size <= '0;
            k_len  <= '0;
            k_addr <= '0;
        end else if (cmd_valid && cmd_ready) begin
            k_kind <= cmd_kind;
            k_size <= cmd_size;
            k_len  <= cmd_len;
            k_addr <= cmd_addr;
        end
    end

    assign k_bytes = ADDR_W'(1) << k_size;
    assign k_span  = k_bytes * (ADDR_W'(k_len) + 1'b1);
    assign k_bound = k_addr & ~(k_span - 1'b1);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_last));

    // R8
    busy_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !cmd_ready);

    // R3
    fixed_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_last && k_kind == 2'd0
        |=> beat_addr == $past(beat_addr));

    // R4
    incr_step_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_last && k_kind == 2'd1
        |=> beat_addr == (($past(beat_addr) & ~(k_bytes - 1'b1)) + k_bytes));

    // R5
    wrap_window_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && k_kind == 2'd2 |-> (beat_addr & ~(k_span - 1'b1)) == k_bound);

    // R1
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && beat_last |=> !beat_valid);

    // R10
    err_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid && cmd_ready));

    // R6
    err_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !beat_valid);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .cmd_size   (cmd_size),
    .cmd_kind   (cmd_kind),
    .cmd_err    (cmd_err),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_last  (beat_last)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_len = '0;
    logic [2:0]        cmd_size = '0;
    logic [1:0]        cmd_kind = '0;
    logic              cmd_err;
    logic              beat_valid;
    logic              beat_ready = 1'b0;
    logic [ADDR_W-1:0] beat_addr;
    logic              beat_last;

    int checks = 0;
    int failures = 0;
    int stall_ctr = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_kind(cmd_kind),
        .cmd_err(cmd_err),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_legal(input int kind, input int size, input int len, input longint a);
        longint bytes = longint'(1) << size;
        int     beats = len + 1;
        case (kind)
            0: return beats <= 16;
            1: return 1'b1;
            2: return (beats == 2 || beats == 4 || beats == 8 || beats == 16) && (a % bytes == 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_addr(input int kind, input int size, input int len,
                                             input longint a, input int i);
        longint bytes = longint'(1) << size;
        longint span  = bytes * (len + 1);
        longint bound;
        if (kind == 0 || i == 0) return a[31:0];
        if (kind == 1) return 32'((a / bytes) * bytes + longint'(i) * bytes);
        bound = (a / span) * span;
        return 32'(bound + ((a - bound) + longint'(i) * bytes) % span);
    endfunction

    task automatic run_cmd(input int kind, input int size, input int len, input logic [31:0] a);
        bit           legal = exp_legal(kind, size, len, longint'(a));
        string        atag = (kind == 0) ? "R3" : (kind == 1) ? "R4,R2" : "R5,R2";
        int           idx = 0;
        bit           done = 1'b0;
        bit           held = 1'b0;
        logic [31:0]  held_addr = '0;
        bit           held_last = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_size = 3'(size);
        cmd_len = 8'(len); cmd_addr = a;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!legal) begin
            chk(cmd_err == 1'b1, (kind == 2) ? "R6 err raised" : "R7 err raised", 64'(cmd_err), 64'd1);
            chk(beat_valid == 1'b0, (kind == 2) ? "R6 no beats" : "R7 no beats", 64'(beat_valid), 64'd0);
            @(negedge clk);
            chk(cmd_err == 1'b0, "R10 err one cycle", 64'(cmd_err), 64'd0);
            chk(beat_valid == 1'b0 && cmd_ready == 1'b1, "R6 idle after err",
                64'({beat_valid, cmd_ready}), 64'b01);
        end else begin
            chk(cmd_err == 1'b0, "R10 no err on legal", 64'(cmd_err), 64'd0);
            while (!done) begin
                if (held)
                    chk(beat_valid && beat_addr == held_addr && beat_last == held_last,
                        "R8 stall hold", 64'(beat_addr), 64'(held_addr));
                chk(beat_valid == 1'b1 && cmd_ready == 1'b0, "R8 busy", 64'({beat_valid, cmd_ready}), 64'b10);
                stall_ctr++;
                beat_ready = (stall_ctr % 4) != 3;
                if (beat_valid && beat_ready) begin
                    chk(beat_addr == exp_addr(kind, size, len, longint'(a), idx), atag,
                        64'(beat_addr), 64'(exp_addr(kind, size, len, longint'(a), idx)));
                    chk(beat_last == (idx == len), "R1 last flag", 64'(beat_last), 64'(idx == len));
                    if (idx == len) done = 1'b1;
                    idx++;
                    held = 1'b0;
                end else begin
                    held = 1'b1;
                    held_addr = beat_addr;
                    held_last = beat_last;
                end
                @(negedge clk);
            end
            beat_ready = 1'b0;
            chk(beat_valid == 1'b0 && cmd_ready == 1'b1, "R1 beat count", 64'({beat_valid, cmd_ready}), 64'b01);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lens[8] = '{0, 1, 2, 3, 7, 15, 16, 255};
        logic [31:0] addrs[3] = '{32'h24, 32'h1003, 32'hABC0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(cmd_ready == 1'b1, "R9 cmd_ready", 64'(cmd_ready), 64'd1);
        chk(beat_valid == 1'b0, "R9 beat_valid", 64'(beat_valid), 64'd0);
        chk(cmd_err == 1'b0, "R9 cmd_err", 64'(cmd_err), 64'd0);
        rst = 1'b0;

        // R5 the worked wrap example first
        run_cmd(2, 1, 3, 32'h24);
        // R7 reserved type code
        run_cmd(3, 0, 0, 32'h40);

        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 8; s++)
                for (int l = 0; l < 8; l++)
                    for (int j = 0; j < 3; j++)
                        run_cmd(k, s, lens[l], addrs[j]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule